// File: doc/BRIEF.md
# Fault-Tolerant Redundant Bit-Stream Multiplier

This block multiplies two unsigned operands without ever forming a binary product in its arithmetic core. Each one-bit partial product `opA[i] & opB[j]` is written several times into a unary stream that belongs to the column of weight `2^(i+j)`. Every column stream also carries a small group of bits fixed at one. The product therefore exists as a set of independent per-column ones-counts. A stray flip of any single stream bit moves that count by one. It cannot carry into other columns or change a whole word.

Each stream bit passes through an XOR with a per-bit fault mask before it leaves the block and before it is decoded. A test environment can therefore upset any pattern of bits it chooses. The decoder counts the ones in each column and discards the low redundancy bits of that count, which leaves the column value. It then adds the column values at their weights to form a binary product of double width. The decoder is not itself hardened. The whole path is combinational. With the default redundancy of 3, each partial product gets 8 copies and each column gets 4 bias ones. The stream is 572 bits wide.

Top module: `bsm_streamMult`

## Requirements
- R1: `streamOut` is laid out column by column in ascending weight, with column k (k = 0 to 14) occupying 8·P(k)+4 bits. P(k) is the number of pairs (i, j) with i+j = k and 0 ≤ i, j ≤ 7. Inside a column, pairs come in ascending i, followed by the 4 bias bits at the top. The total is 572 bits.
- R2: Each partial product `opA[i] & opB[j]` appears as 8 adjacent identical bits at its slot in column i+j.
- R3: The top 4 bits of every column are 1 for all operands when the fault mask is zero.
- R4: `streamOut` equals the fault-free stream XOR `faultMask`, bit for bit.
- R5: With a zero fault mask, `product` equals `opA × opB`.
- R6: With a zero fault mask, the ones-count of column k equals 8·(Σ over its pairs of `opA[i]&opB[j]`) + 4.
- R7: `product` stays `opA × opB` when any column receives up to 3 more 0→1 flips than 1→0 flips.
- R8: `product` stays `opA × opB` when any column receives up to 4 more 1→0 flips than 0→1 flips.
- R9: Flips in every column at once, including pairs of opposite flips that cancel, leave `product` exact as long as each column's net flip count is within the R7/R8 limits.
- R10: The decoded column value is floor(count/8). So a column k pushed by a net of +4 yields `opA×opB + 2^k` (mod 2^16), and a column pushed down by 5 from 8v+4 yields one unit less at its weight.
- R11: The datapath has no clock. `product` and `streamOut` follow an input change without any clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opA | input | 8 | Unsigned multiplicand |
| opB | input | 8 | Unsigned multiplier |
| faultMask | input | 572 | Per-stream-bit XOR upset mask |
| streamOut | output | 572 | Redundant column streams after fault injection |
| product | output | 16 | Decoded binary product |

## Verification
The two functions that meet in one evaluation are stream generation, which places fresh partial-product copies, and fault injection, which upsets bits of that same stream before the decoder counts them. The bench provokes this by building masks from the expected stream of the current operands. It picks exact numbers of upward and downward flips per column, sometimes adding cancelling pairs, and applies them together with new operands. It judges the result by comparing `streamOut` against the expected stream XOR the mask. It also compares `product` against the exact product when every column's net flip count is inside the tolerance. Directed masks just past the limit must shift the product by exactly one unit at that column's weight.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  // number of (i,j) operand-bit pairs with i+j == k
  function automatic int colPairs(input int opW, input int k);
    int lo;
    int hi;
    lo = (k > opW - 1) ? k - opW + 1 : 0;
    hi = (k < opW - 1) ? k : opW - 1;
    return hi - lo + 1;
  endfunction

  // lowest operand-A index feeding column k
  function automatic int colLowA(input int opW, input int k);
    return (k > opW - 1) ? k - opW + 1 : 0;
  endfunction

  function automatic int colWidth(input int opW, input int k, input int copies, input int bias);
    return colPairs(opW, k) * copies + bias;
  endfunction

  function automatic int colOffset(input int opW, input int k, input int copies, input int bias);
    int sum;
    sum = 0;
    for (int m = 0; m < k; m++) sum += colWidth(opW, m, copies, bias);
    return sum;
  endfunction

  function automatic int streamWidth(input int opW, input int copies, input int bias);
    return colOffset(opW, 2 * opW - 1, copies, bias);
  endfunction

  function automatic int countWidth(input int opW, input int copies, input int bias);
    return $clog2(opW * copies + bias + 1);
  endfunction

endpackage

// File: rtl/bsm_streamGen.sv
module bsm_streamGen #(
  parameter int OP_W     = 8,
  parameter int COPIES   = 8,
  parameter int BIAS     = 4,
  parameter int STREAM_W = 572
) (
  input  logic [OP_W-1:0]     opA,
  input  logic [OP_W-1:0]     opB,
  output logic [STREAM_W-1:0] rawStream
);
  import bsm_pkg::*;

  localparam int NCOL = 2 * OP_W - 1;

  for (genvar i = 0; i < OP_W; i++) begin : gA
    for (genvar j = 0; j < OP_W; j++) begin : gB
      localparam int K    = i + j;
      localparam int BASE = colOffset(OP_W, K, COPIES, BIAS) + (i - colLowA(OP_W, K)) * COPIES;
      assign rawStream[BASE +: COPIES] = {COPIES{opA[i] & opB[j]}};
    end
  end

  for (genvar k = 0; k < NCOL; k++) begin : gBias
    localparam int TOP = colOffset(OP_W, k, COPIES, BIAS) + colPairs(OP_W, k) * COPIES;
    assign rawStream[TOP +: BIAS] = {BIAS{1'b1}};
  end

endmodule

// File: rtl/bsm_colDecode.sv
module bsm_colDecode #(
  parameter int OP_W     = 8,
  parameter int COPIES   = 8,
  parameter int BIAS     = 4,
  parameter int STREAM_W = 572,
  parameter int CNT_W    = 7
) (
  input  logic [STREAM_W-1:0]             stream,
  output logic [2*OP_W-2:0][CNT_W-1:0]    colCount
);
  import bsm_pkg::*;

  localparam int NCOL = 2 * OP_W - 1;

  for (genvar k = 0; k < NCOL; k++) begin : gCol
    localparam int OFF = colOffset(OP_W, k, COPIES, BIAS);
    localparam int WID = colWidth(OP_W, k, COPIES, BIAS);
    always_comb begin
      logic [CNT_W-1:0] acc;
      acc = '0;
      for (int n = 0; n < WID; n++) acc = acc + CNT_W'(stream[OFF + n]);
      colCount[k] = acc;
    end
  end

endmodule

// File: rtl/bsm_weightSum.sv
module bsm_weightSum #(
  parameter int NCOL   = 15,
  parameter int CNT_W  = 7,
  parameter int RED    = 3,
  parameter int PROD_W = 16
) (
  input  logic [NCOL-1:0][CNT_W-1:0] colCount,
  output logic [PROD_W-1:0]          product
);

  always_comb begin
    logic [PROD_W-1:0] acc;
    acc = '0;
    for (int k = 0; k < NCOL; k++)
      acc = acc + (PROD_W'(colCount[k] >> RED) << k);
    product = acc;
  end

endmodule

// File: rtl/bsm_streamMult.sv
module bsm_streamMult #(
  parameter  int OP_W     = 8,
  parameter  int RED      = 3,
  localparam int COPIES   = 1 << RED,
  localparam int BIAS     = 1 << (RED - 1),
  localparam int STREAM_W = bsm_pkg::streamWidth(OP_W, COPIES, BIAS)
) (
  input  logic [OP_W-1:0]     opA,
  input  logic [OP_W-1:0]     opB,
  input  logic [STREAM_W-1:0] faultMask,
  output logic [STREAM_W-1:0] streamOut,
  output logic [2*OP_W-1:0]   product
);
  import bsm_pkg::*;

  localparam int NCOL   = 2 * OP_W - 1;
  localparam int PROD_W = 2 * OP_W;
  localparam int CNT_W  = countWidth(OP_W, COPIES, BIAS);

  logic [STREAM_W-1:0]         rawStream;
  logic [NCOL-1:0][CNT_W-1:0]  colCount;

  bsm_streamGen #(.OP_W(OP_W), .COPIES(COPIES), .BIAS(BIAS), .STREAM_W(STREAM_W)) uGen (
    .opA(opA), .opB(opB), .rawStream(rawStream)
  );

  assign streamOut = rawStream ^ faultMask;

  bsm_colDecode #(.OP_W(OP_W), .COPIES(COPIES), .BIAS(BIAS), .STREAM_W(STREAM_W), .CNT_W(CNT_W)) uDec (
    .stream(streamOut), .colCount(colCount)
  );

  bsm_weightSum #(.NCOL(NCOL), .CNT_W(CNT_W), .RED(RED), .PROD_W(PROD_W)) uSum (
    .colCount(colCount), .product(product)
  );

  logic inputsKnown;
  logic cleanRun;
  assign inputsKnown = !$isunknown({opA, opB, faultMask});
  assign cleanRun    = inputsKnown && (faultMask == '0);

  always_comb begin
    if (cleanRun)
      AST_CLEAN_PRODUCT: assert (product == ({{OP_W{1'b0}}, opA} * {{OP_W{1'b0}}, opB})); // R5
  end

  for (genvar k = 0; k < NCOL; k++) begin : gChk
    localparam int TOP = colOffset(OP_W, k, COPIES, BIAS) + colPairs(OP_W, k) * COPIES;
    always_comb begin
      if (cleanRun) begin
        AST_BIAS_RESIDUE: assert ((colCount[k] & CNT_W'(COPIES - 1)) == CNT_W'(BIAS)); // R6
        AST_BIAS_TOP: assert (streamOut[TOP +: BIAS] == {BIAS{1'b1}}); // R3
        if (opA == '0)
          AST_ZERO_OPERAND: assert (colCount[k] == CNT_W'(BIAS)); // R2
      end
    end
  end

endmodule

// File: tb/tb_bsm_streamMult.sv
module tb_bsm_streamMult;
  localparam int CLK_PERIOD = 10;
  localparam int SW = 572;

  logic clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic [7:0]    opA, opB;
  logic [SW-1:0] faultMask;
  logic [SW-1:0] streamOut;
  logic [15:0]   product;

  int testsRun = 0;
  int testsFailed = 0;

  bsm_streamMult dut (
    .opA(opA), .opB(opB), .faultMask(faultMask),
    .streamOut(streamOut), .product(product)
  );

  function automatic int pairsTb(input int k);
    int n = 0;
    for (int i = 0; i < 8; i++) if (k - i >= 0 && k - i < 8) n++;
    return n;
  endfunction

  function automatic int lenTb(input int k);
    return 8 * pairsTb(k) + 4;
  endfunction

  function automatic int startTb(input int k);
    int s = 0;
    for (int m = 0; m < k; m++) s += lenTb(m);
    return s;
  endfunction

  function automatic logic [SW-1:0] expStream(input logic [7:0] a, input logic [7:0] b);
    logic [SW-1:0] s;
    int pos = 0;
    s = '0;
    for (int k = 0; k < 15; k++) begin
      for (int i = 0; i < 8; i++) begin
        if (k - i >= 0 && k - i < 8)
          for (int c = 0; c < 8; c++) begin s[pos] = a[i] & b[k - i]; pos++; end
      end
      for (int c = 0; c < 4; c++) begin s[pos] = 1'b1; pos++; end
    end
    return s;
  endfunction

  function automatic int colOnes(input logic [SW-1:0] s, input int k);
    int n = 0;
    for (int p = 0; p < lenTb(k); p++) n += int'(s[startTb(k) + p]);
    return n;
  endfunction

  function automatic int colValTb(input logic [7:0] a, input logic [7:0] b, input int k);
    int n = 0;
    for (int i = 0; i < 8; i++) if (k - i >= 0 && k - i < 8) n += int'(a[i] & b[k - i]);
    return n;
  endfunction

  // per-column mask with exact up/down flip counts, net kept within tolerance
  function automatic logic [SW-1:0] makeMask(input logic [7:0] a, input logic [7:0] b,
                                             input int upMax, input int downMax, input bit cancel);
    logic [SW-1:0] clean, m;
    clean = expStream(a, b);
    m = '0;
    for (int k = 0; k < 15; k++) begin
      int ones = colOnes(clean, k);
      int zeros = lenTb(k) - ones;
      int u = int'($urandom % (upMax + 1));
      int d = int'($urandom % (downMax + 1));
      int st = int'($urandom % lenTb(k));
      int gu = 0, gd = 0;
      if (cancel) begin int e = int'($urandom % 3); u += e; d += e; end
      if (u > zeros) u = zeros;
      if (d > ones) d = ones;
      if (u - d > 3) u = d + 3;
      if (d - u > 4) d = u + 4;
      for (int n = 0; n < lenTb(k); n++) begin
        int idx = startTb(k) + (st + n) % lenTb(k);
        if (!clean[idx] && gu < u) begin m[idx] = 1'b1; gu++; end
        else if (clean[idx] && gd < d) begin m[idx] = 1'b1; gd++; end
      end
    end
    return m;
  endfunction

  task automatic checkProd(input string tag, input logic [15:0] act, input logic [15:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s product act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic checkStream(input string tag, input logic [SW-1:0] act, input logic [SW-1:0] exp);
    testsRun++;
    if (act !== exp) begin
      testsFailed++;
      $display("FAIL %s stream act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic checkInt(input string tag, input int act, input int exp);
    testsRun++;
    if (act != exp) begin
      testsFailed++;
      $display("FAIL %s act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic apply(input logic [7:0] a, input logic [7:0] b, input logic [SW-1:0] m);
    @(negedge clk);
    opA = a; opB = b; faultMask = m;
    #(CLK_PERIOD / 4);
  endtask

  task automatic cleanCheck(input logic [7:0] a, input logic [7:0] b);
    apply(a, b, '0);
    checkStream("R1/R2 layout", streamOut, expStream(a, b));
    checkProd("R5 clean", product, 16'(a * b));
    for (int k = 0; k < 15; k++) begin
      checkInt("R6 count", colOnes(streamOut, k), 8 * colValTb(a, b, k) + 4);
      checkInt("R3 bias", int'(streamOut[startTb(k) + lenTb(k) - 4 +: 4]), 15);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    testsFailed++;
    $display("FAIL watchdog expired");
    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [SW-1:0] m;
    logic [7:0] a, b;
    void'($urandom(32'd1234));
    opA = '0; opB = '0; faultMask = '0;
    #(CLK_PERIOD / 4);
    // idle state: zero operands, only bias bits set
    checkProd("R5 idle", product, 16'd0);
    checkStream("R3 idle", streamOut, expStream(8'd0, 8'd0));

    // R11: change operands in mid clock phase, no edge in between
    @(posedge clk); #1;
    opA = 8'd13; opB = 8'd11; #1;
    checkProd("R11 no clock", product, 16'd143);

    cleanCheck(8'hFF, 8'hFF);
    cleanCheck(8'h01, 8'h80);
    cleanCheck(8'hAA, 8'h55);
    for (int t = 0; t < 60; t++) cleanCheck(8'($urandom), 8'($urandom));

    // R4: arbitrary mask appears XORed on the output
    a = 8'h3C; b = 8'hC3;
    m = '0;
    for (int w = 0; w < SW / 32 + 1; w++) m[w * 32 +: 32] = $urandom;
    apply(a, b, m);
    checkStream("R4 xor", streamOut, expStream(a, b) ^ m);

    // R7: up flips only, 3 per column at the worst
    apply(8'h00, 8'h00, makeMask(8'h00, 8'h00, 3, 0, 1'b0));
    checkProd("R7 zero up", product, 16'd0);
    for (int t = 0; t < 150; t++) begin
      a = 8'($urandom); b = 8'($urandom);
      m = makeMask(a, b, 3, 0, 1'b0);
      apply(a, b, m);
      checkStream("R4 up", streamOut, expStream(a, b) ^ m);
      checkProd("R7 up", product, 16'(a * b));
    end

    // R8: down flips only, 4 per column at the worst
    apply(8'hFF, 8'hFF, makeMask(8'hFF, 8'hFF, 0, 4, 1'b0));
    checkProd("R8 max down", product, 16'd65025);
    for (int t = 0; t < 150; t++) begin
      a = 8'($urandom); b = 8'($urandom);
      apply(a, b, makeMask(a, b, 0, 4, 1'b0));
      checkProd("R8 down", product, 16'(a * b));
    end

    // R9: mixed and cancelling flips in all columns
    for (int t = 0; t < 200; t++) begin
      a = 8'($urandom); b = 8'($urandom);
      apply(a, b, makeMask(a, b, 3, 4, 1'b1));
      checkProd("R9 mixed", product, 16'(a * b));
    end

    // R10: one flip past each limit
    m = '0;
    for (int p = 0; p < 4; p++) m[startTb(7) + p] = 1'b1;
    apply(8'd0, 8'd0, m);
    checkProd("R10 up4 col7", product, 16'd128);
    m = '0;
    for (int p = 0; p < 5; p++) m[startTb(0) + p] = 1'b1;
    apply(8'hFF, 8'hFF, m);
    checkProd("R10 down5 col0", product, 16'd65024);
    m = '0;
    for (int p = 0; p < 4; p++) m[startTb(14) + p] = 1'b1;
    apply(8'h00, 8'h00, m);
    checkProd("R10 up4 col14", product, 16'h4000);

    $display("  [TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule